// File: doc/BRIEF.md
# Oversampled Conversion Sequencer with Register Bank

This block sits between a byte-wide register bus and the digital side of an oversampling modulator. Software programs the conversion shape through eight 8-bit registers. Six of them hold configuration and two hold a 16-bit signed result. A conversion is then started either once or in a repeating loop.

Each conversion runs as 2^E elementary conversions, where E comes from a 2-bit field. Each elementary conversion takes 2^(3+K) accepted modulator samples, where K comes from a 3-bit field. The chop polarity starts positive and flips at every elementary-conversion boundary. Every accepted sample is sign-corrected by the current polarity and added to a running sum. At the end of the conversion the sum is clamped to 16 bits and lands in the result registers in a single cycle, and a one-cycle completion pulse follows.

A start request that arrives while a conversion runs is held and served right after it. The continuous bit keeps conversions coming back to back. Clearing the continuous bit lets the current conversion finish and then halts.

Top module: `ovs_seq`

## Requirements
- R1: After reset the registers read as follows: address 0 reads 0x00, address 1 reads 0x09 (elementary exponent 1, oversampling exponent 2), address 2 reads 0x01, and addresses 3 to 7 read 0x00. `busy` and `convDone` are low.
- R2: The register fields are laid out as follows. Address 1 bits 1:0 hold the elementary-count exponent and bits 4:2 hold the oversampling exponent, and its other bits read 0. Address 2 bits 3:0 hold the enable field, and its other bits read 0. Addresses 3, 4 and 5 are plain read/write bytes that appear on `auxCfg` (address 3 in the low byte). Writes to addresses 6 and 7 are ignored.
- R3: Address 0 bit 0 is a write-only start request and always reads 0. Address 0 bit 2 is a test bit that always reads 0, whatever is written to it.
- R4: A conversion accepts exactly 2^E · 2^(3+K) samples on cycles where `modValid` is high. Cycles where `modValid` is low are ignored. The polarity on `modChop` is 0 (positive) for the first elementary conversion and alternates after that. The result is the sum of each sample, negated while `modChop` is 1.
- R5: A start request written while `busy` is high produces exactly one further conversion after the current one ends.
- R6: Address 0 bit 1 is the continuous bit. While it is 1, a new conversion starts one cycle after each one ends. Clearing it during a conversion lets that conversion finish, and no further conversion starts.
- R7: The final sum is clamped to the range -32768..32767. Address 6 reads result bits 15:8 and address 7 reads bits 7:0. The result changes only at the end of a conversion.
- R8: `busy` (also address 0 bit 7) is high from the cycle after a start until the final sample is accepted. `convDone` is high for exactly one cycle, the first cycle in which the new result can be read.
- R9: `modEnable` follows enable bit 0. `stageBypass[i]` is high when enable bit i+1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for `busAddr` |
| modValid | input | 1 | Modulator sample is valid this cycle |
| modSample | input | SAMPLE_W (4) | Signed modulator sample |
| modChop | output | 1 | Current chop polarity (1 = inverted) |
| modEnable | output | 1 | Modulator enable |
| stageBypass | output | 3 | Amplifier stage bypass flags |
| auxCfg | output | 24 | Contents of the three plain configuration bytes |
| busy | output | 1 | Conversion in progress |
| convDone | output | 1 | One-cycle completion pulse |

## Verification
The corner cases the bench targets are:
- Chop boundaries. A sequencer that flipped polarity one sample late or early would give a wrong sum, because the bench's sample pattern is not symmetric.
- Stall cycles with a distinctive sample on the input. A design that accumulated while `modValid` was low would shift the sum.
- The largest conversion, fed so that every term has the same sign. A missing or wrapped clamp would show up as a mid-range value instead of 32767 or -32768.
- A start request queued during a conversion, and a continuous bit cleared at the start of a conversion. Dropping the request, serving it twice, or stopping early would each show up as `busy` at the wrong time.

// File: rtl/ovs_seq_pkg.sv
package ovs_seq_pkg;

  localparam int REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_SHAPE  = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_ENABLE = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_AUX0   = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_AUX1   = 3'd4;
  localparam logic [REG_ADDR_W-1:0] ADDR_AUX2   = 3'd5;
  localparam logic [REG_ADDR_W-1:0] ADDR_RESHI  = 3'd6;
  localparam logic [REG_ADDR_W-1:0] ADDR_RESLO  = 3'd7;

  // strobes from the sequencer control to the datapath
  typedef struct packed {
    logic clearAcc;
    logic accumEn;
    logic negate;
    logic latchResult;
  } seqStb_t;

endpackage

// File: rtl/ovs_seq_ctrl.sv
module ovs_seq_ctrl
  import ovs_seq_pkg::*;
#(
  parameter int NELC_EXP_W = 2,
  parameter int OSR_EXP_W  = 3,
  parameter int OSR_BASE   = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic                  contEn,
  input  logic [NELC_EXP_W-1:0] nelcExp,
  input  logic [OSR_EXP_W-1:0]  osrExp,
  input  logic                  modValid,
  output seqStb_t               stb,
  output logic                  busy,
  output logic                  convDone,
  output logic                  modChop
);

  localparam int SCNT_W = OSR_BASE + (1 << OSR_EXP_W) - 1;
  localparam int ECNT_W = (1 << NELC_EXP_W) - 1;

  logic                  busyQ, pendQ, chopQ, doneQ;
  logic [SCNT_W-1:0]     sampleCnt, osrTop;
  logic [ECNT_W-1:0]     elemCnt, elemTop;
  logic [NELC_EXP_W-1:0] nelcExpQ;
  logic [OSR_EXP_W-1:0]  osrExpQ;
  logic                  startNow, sampleTake, osrLast, elemLast, finish;

  always_comb begin
    osrTop  = SCNT_W'((32'd1 << (OSR_BASE + 32'(osrExpQ))) - 32'd1);
    elemTop = ECNT_W'((32'd1 << 32'(nelcExpQ)) - 32'd1);
  end

  assign startNow   = !busyQ && (pendQ || contEn);
  assign sampleTake = busyQ && modValid;
  assign osrLast    = (sampleCnt == osrTop);
  assign elemLast   = (elemCnt == elemTop);
  assign finish     = sampleTake && osrLast && elemLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      pendQ     <= 1'b0;
      chopQ     <= 1'b0;
      doneQ     <= 1'b0;
      sampleCnt <= '0;
      elemCnt   <= '0;
      nelcExpQ  <= '0;
      osrExpQ   <= '0;
    end else begin
      pendQ <= startReq || (pendQ && !startNow);
      doneQ <= finish;
      if (startNow) begin
        busyQ     <= 1'b1;
        chopQ     <= 1'b0;
        sampleCnt <= '0;
        elemCnt   <= '0;
        nelcExpQ  <= nelcExp;
        osrExpQ   <= osrExp;
      end else if (sampleTake) begin
        if (osrLast) begin
          sampleCnt <= '0;
          chopQ     <= !chopQ;
          elemCnt   <= elemCnt + ECNT_W'(1);
          if (elemLast) busyQ <= 1'b0;
        end else begin
          sampleCnt <= sampleCnt + SCNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    stb.clearAcc    = startNow;
    stb.accumEn     = sampleTake;
    stb.negate      = chopQ;
    stb.latchResult = finish;
  end

  assign busy     = busyQ;
  assign convDone = doneQ;
  assign modChop  = chopQ;

  // R8: completion pulse lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R8: completion only right after the busy phase ends
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (!busyQ && $past(busyQ)));

  // R4: polarity flips at an inner elementary boundary
  a_r4_chop_flip: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTake && osrLast && !elemLast) |=> (chopQ != $past(chopQ)));

  // R4: every conversion starts with positive polarity
  a_r4_chop_first: assert property (@(posedge clk) disable iff (!rstN)
    startNow |=> (busyQ && !chopQ));

  // R5: a queued request survives the running conversion
  a_r5_pend_kept: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && busyQ) |=> pendQ);

  // R4: sample counter never passes its window
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (sampleCnt <= osrTop));

endmodule

// File: rtl/ovs_seq_dp.sv
module ovs_seq_dp
  import ovs_seq_pkg::*;
#(
  parameter int SAMPLE_W   = 4,
  parameter int NELC_EXP_W = 2,
  parameter int OSR_EXP_W  = 3,
  parameter int OSR_BASE   = 3,
  parameter int RES_W      = 16,
  parameter int EN_W       = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrEn,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [7:0]            busWrData,
  output logic [7:0]            busRdData,
  input  logic [SAMPLE_W-1:0]   modSample,
  input  seqStb_t               stb,
  input  logic                  busy,
  output logic                  startReq,
  output logic                  contEn,
  output logic [NELC_EXP_W-1:0] nelcExp,
  output logic [OSR_EXP_W-1:0]  osrExp,
  output logic                  modEnable,
  output logic [EN_W-2:0]       stageBypass,
  output logic [23:0]           auxCfg
);

  localparam int MAX_LOG = (1 << NELC_EXP_W) - 1 + OSR_BASE + (1 << OSR_EXP_W) - 1;
  localparam int ACC_W   = SAMPLE_W + MAX_LOG + 1;
  localparam int AUX_N   = 3;
  localparam int SHAPE_W = NELC_EXP_W + OSR_EXP_W;
  localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((1 << (RES_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] NEG_LIM = -POS_LIM - ACC_W'(1);

  logic                  contQ;
  logic [NELC_EXP_W-1:0] nelcQ;
  logic [OSR_EXP_W-1:0]  osrQ;
  logic [EN_W-1:0]       enQ;
  logic [7:0]            auxQ [AUX_N];
  logic signed [ACC_W-1:0] accQ, ext, term, sumNext;
  logic [RES_W-1:0]      resultQ, satVal;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      contQ <= 1'b0;
      nelcQ <= NELC_EXP_W'(1);
      osrQ  <= OSR_EXP_W'(2);
      enQ   <= EN_W'(1);
    end else if (busWrEn) begin
      case (busAddr)
        ADDR_CTRL:   contQ <= busWrData[1];
        ADDR_SHAPE:  {osrQ, nelcQ} <= busWrData[SHAPE_W-1:0];
        ADDR_ENABLE: enQ <= busWrData[EN_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < AUX_N; g++) begin : gAux
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) auxQ[g] <= '0;
      else if (busWrEn && busAddr == REG_ADDR_W'(ADDR_AUX0 + REG_ADDR_W'(g)))
        auxQ[g] <= busWrData;
    end
  end

  assign startReq    = busWrEn && (busAddr == ADDR_CTRL) && busWrData[0];
  assign contEn      = contQ;
  assign nelcExp     = nelcQ;
  assign osrExp      = osrQ;
  assign modEnable   = enQ[0];
  assign stageBypass = ~enQ[EN_W-1:1];
  assign auxCfg      = {auxQ[2], auxQ[1], auxQ[0]};

  // accumulation with chop sign
  always_comb begin
    ext     = {{(ACC_W - SAMPLE_W){modSample[SAMPLE_W-1]}}, modSample};
    term    = stb.negate ? -ext : ext;
    sumNext = accQ + term;
    if (sumNext > POS_LIM)      satVal = POS_LIM[RES_W-1:0];
    else if (sumNext < NEG_LIM) satVal = NEG_LIM[RES_W-1:0];
    else                        satVal = sumNext[RES_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ    <= '0;
      resultQ <= '0;
    end else begin
      if (stb.clearAcc)     accQ <= '0;
      else if (stb.accumEn) accQ <= sumNext;
      if (stb.latchResult)  resultQ <= satVal;
    end
  end

  // read mux
  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_CTRL:   busRdData = {busy, 5'b0, contQ, 1'b0};
      ADDR_SHAPE:  busRdData = 8'({osrQ, nelcQ});
      ADDR_ENABLE: busRdData = 8'(enQ);
      ADDR_AUX0:   busRdData = auxQ[0];
      ADDR_AUX1:   busRdData = auxQ[1];
      ADDR_AUX2:   busRdData = auxQ[2];
      ADDR_RESHI:  busRdData = resultQ[RES_W-1:RES_W-8];
      ADDR_RESLO:  busRdData = resultQ[7:0];
      default:     busRdData = '0;
    endcase
  end

  // R7: result only moves on the completion strobe
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latchResult |=> $stable(resultQ));

  // R4: stalled cycles leave the running sum alone
  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.accumEn && !stb.clearAcc) |=> $stable(accQ));

  // R4: a fresh conversion begins from zero
  a_r4_acc_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearAcc |=> (accQ == '0));

endmodule

// File: rtl/ovs_seq.sv
module ovs_seq
  import ovs_seq_pkg::*;
#(
  parameter int SAMPLE_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [2:0]          busAddr,
  input  logic [7:0]          busWrData,
  output logic [7:0]          busRdData,
  input  logic                modValid,
  input  logic [SAMPLE_W-1:0] modSample,
  output logic                modChop,
  output logic                modEnable,
  output logic [2:0]          stageBypass,
  output logic [23:0]         auxCfg,
  output logic                busy,
  output logic                convDone
);

  localparam int NELC_EXP_W = 2;
  localparam int OSR_EXP_W  = 3;
  localparam int OSR_BASE   = 3;

  seqStb_t               stb;
  logic                  startReq, contEn;
  logic [NELC_EXP_W-1:0] nelcExp;
  logic [OSR_EXP_W-1:0]  osrExp;

  ovs_seq_ctrl #(
    .NELC_EXP_W(NELC_EXP_W), .OSR_EXP_W(OSR_EXP_W), .OSR_BASE(OSR_BASE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .contEn(contEn),
    .nelcExp(nelcExp), .osrExp(osrExp), .modValid(modValid),
    .stb(stb), .busy(busy), .convDone(convDone), .modChop(modChop)
  );

  ovs_seq_dp #(
    .SAMPLE_W(SAMPLE_W), .NELC_EXP_W(NELC_EXP_W), .OSR_EXP_W(OSR_EXP_W),
    .OSR_BASE(OSR_BASE), .RES_W(16), .EN_W(4)
  ) dp_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .modSample(modSample),
    .stb(stb), .busy(busy), .startReq(startReq), .contEn(contEn),
    .nelcExp(nelcExp), .osrExp(osrExp), .modEnable(modEnable),
    .stageBypass(stageBypass), .auxCfg(auxCfg)
  );

endmodule

// File: tb/ovs_seq_tb_top.sv
module ovs_seq_tb_top;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrEn = 1'b0;
  logic [2:0]        busAddr = '0;
  logic [7:0]        busWrData = '0;
  logic [7:0]        busRdData;
  logic              modValid = 1'b0;
  logic signed [3:0] modSample = '0;
  logic              modChop, modEnable, busy, convDone;
  logic [2:0]        stageBypass;
  logic [23:0]       auxCfg;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ovs_seq #(.SAMPLE_W(4)) dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .modValid(modValid),
    .modSample(modSample), .modChop(modChop), .modEnable(modEnable),
    .stageBypass(stageBypass), .auxCfg(auxCfg), .busy(busy), .convDone(convDone)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      summary();
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    busAddr = a; #1; d = busRdData;
  endtask

  function automatic int sampleFor(input int pat, input int k, input bit chopE);
    case (pat)
      0: return ((k * 5 + 3) % 15) - 7;
      1: return (k % 2 == 0) ? -8 : 7;
      2: return chopE ? -7 : 7;
      default: return chopE ? 7 : -8;
    endcase
  endfunction

  task automatic runConv(input int nelcE, input int osrE, input int pat, input string req);
    int n, k, w, s;
    longint expSum;
    int chopBad;
    bit chopE, gap, gapped;
    logic [7:0] hi, lo;
    n = (1 << nelcE) * (1 << (osrE + 3));
    k = 0; w = 0; expSum = 0; chopBad = 0; gapped = 0;
    while (!busy && w < 20) begin @(negedge clk); w++; end
    check({req, " busy at start"}, busy, 1);
    while (k < n) begin
      chopE = ((k >> (osrE + 3)) & 1) != 0;
      gap = (k % 9 == 4) && !gapped;
      if (gap) begin
        modValid = 1'b0; modSample = 4'sd5; gapped = 1;
      end else begin
        s = sampleFor(pat, k, chopE);
        modValid = 1'b1; modSample = 4'(s); gapped = 0;
        if (modChop != chopE) chopBad++;
        expSum += chopE ? -s : s;
      end
      @(negedge clk);
      if (!gap) k++;
    end
    modValid = 1'b0;
    if (expSum > 32767) expSum = 32767;
    if (expSum < -32768) expSum = -32768;
    check("R4 chop polarity per elementary conversion", chopBad, 0);
    check("R8 done pulse after final sample", convDone, 1);
    check("R8 busy low after final sample", busy, 0);
    rd(3'd6, hi); rd(3'd7, lo);
    check({req, " R7 result"}, longint'($signed({hi, lo})), expSum);
    @(negedge clk);
    check("R8 done lasts one cycle", convDone, 0);
  endtask

  initial begin
    logic [7:0] d;
    #5;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(3'd0, d); check("R1 addr0", d, 8'h00);
    rd(3'd1, d); check("R1 addr1", d, 8'h09);
    rd(3'd2, d); check("R1 addr2", d, 8'h01);
    for (int a = 3; a < 8; a++) begin
      rd(3'(a), d); check("R1 addr3..7", d, 0);
    end
    check("R1 busy", busy, 0);
    check("R1 done", convDone, 0);

    // R2 field layout, R9 enable outputs
    wr(3'd1, 8'hFF); rd(3'd1, d); check("R2 shape mask", d, 8'h1F);
    wr(3'd2, 8'hFF); rd(3'd2, d); check("R2 enable mask", d, 8'h0F);
    check("R9 modEnable on", modEnable, 1);
    check("R9 bypass none", stageBypass, 3'b000);
    wr(3'd2, 8'h04);
    check("R9 modEnable off", modEnable, 0);
    check("R9 bypass pattern", stageBypass, 3'b101);
    wr(3'd3, 8'hA1); wr(3'd4, 8'h5B); wr(3'd5, 8'hC7);
    rd(3'd4, d); check("R2 aux readback", d, 8'h5B);
    check("R2 auxCfg", auxCfg, 24'hC75BA1);
    wr(3'd6, 8'h55); wr(3'd7, 8'hAA);
    rd(3'd6, d); check("R2 result hi write ignored", d, 0);
    rd(3'd7, d); check("R2 result lo write ignored", d, 0);

    // R3 test bit reads zero, does not start anything
    wr(3'd0, 8'h04); rd(3'd0, d); check("R3 test bit reads 0", d, 0);
    @(negedge clk); check("R3 test bit no start", busy, 0);

    // R4 sweep of shape fields
    for (int ne = 0; ne < 4; ne++) begin
      for (int oe = 0; oe < 3; oe++) begin
        wr(3'd1, 8'((oe << 2) | ne));
        wr(3'd0, 8'h01);
        @(negedge clk);
        rd(3'd0, d);
        check("R3 start reads 0 / R8 busy bit", d, 8'h80);
        runConv(ne, oe, (ne + oe) % 2, "R4 sweep");
        repeat (3) @(negedge clk);
        check("R4 single shot stops", busy, 0);
      end
    end

    // R5 queued start
    wr(3'd1, 8'h05);
    wr(3'd0, 8'h01);
    while (!busy) @(negedge clk);
    wr(3'd0, 8'h01);
    runConv(1, 1, 0, "R5 first");
    runConv(1, 1, 1, "R5 queued");
    repeat (5) @(negedge clk);
    check("R5 exactly one extra conversion", busy, 0);

    // R6 continuous mode
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h02);
    runConv(1, 0, 0, "R6 cont first");
    runConv(1, 0, 1, "R6 cont second");
    wr(3'd0, 8'h00);
    check("R6 conversion running after clear", busy, 1);
    runConv(1, 0, 0, "R6 cont last");
    repeat (5) @(negedge clk);
    check("R6 halted after clear", busy, 0);

    // R7 saturation at both ends, largest conversion
    wr(3'd1, 8'h1F);
    wr(3'd0, 8'h01);
    runConv(3, 7, 2, "R7 positive clamp");
    wr(3'd0, 8'h01);
    runConv(3, 7, 3, "R7 negative clamp");

    summary();
  end

endmodule